// File: doc/BRIEF.md
# Turn-Sliced DRAM Transaction Scheduler

This block sits in front of a memory device that is shared by several mutually distrusting security domains. Each domain pushes read and write transactions into a private queue. The scheduler hands the memory to one domain at a time, in fixed turns. A ring of per-slot settings gives the owner and the length of each turn, and a start offset sets when the first turn begins after reset. During a turn, only the owning domain's queue can issue, in arrival order. Every issued transaction is a closed-row access, so no open-row state carries from one turn into the next.

The block never lets a transaction start late enough to run into the next owner's turn. For that reason, the tail of every turn is closed to new issues. Writes take longer to drain than reads, so the closed tail is shorter for reads than for writes, and reads can use more of each turn. Within a turn, back-to-back issues are kept apart by gaps that follow from the device timing: one gap for two transactions of the same type, one for a read followed by a write, and one for a write followed by a read. Each issued transaction returns a completion a fixed number of cycles later. The completion is flagged on the valid line of the domain that issued it. The block only decides when whole transactions go out; it does not generate the individual device commands.

Top module: `tdm_mem_sched`

## Requirements
- R1: After reset, every queue is empty (all `req_ready` bits high), nothing issues and no completion is flagged. No turn is active until `cfg_offset` cycles have passed since reset was released, and nothing issues during that time.
- R2: Each domain has its own first-in first-out queue of `QDEPTH` entries. `req_ready[d]` is low exactly when queue d is full, and a request offered while the queue is full is dropped. Transactions of one domain issue in the order they were accepted.
- R3: Turns follow the ring slots 0, 1, …, `RING_LEN`-1 and then wrap back to slot 0. Slot s takes its owner from `cfg_owner[s*DOM_W +: DOM_W]` and its length from `cfg_len[s*TURN_W +: TURN_W]`. The first cycle of slot 0 is cycle `cfg_offset` after reset release.
- R4: At most one transaction issues per cycle. It comes from the head of the current turn owner's queue, and `iss_dom` carries that owner.
- R5: A read may issue only while its turn has more than `RD_CUT` cycles left, counting the issue cycle (position p in a turn of length L needs p + `RD_CUT` < L).
- R6: A write may issue only while p + `WR_CUT` < L, with `WR_CUT` larger than `RD_CUT`.
- R7: A head that is held back by its cutoff blocks the entries behind it, even when a later entry is of the other type and would be allowed.
- R8: Within one turn, an issue at t2 after an issue at t1 needs t2 - t1 ≥ G. G is `T_FAW`-3·`T_RRD` for two issues of the same type, `T_CL`+`T_BURST`+`T_RTRS`-`T_WL` for a read then a write, and `T_WL`+`T_BURST`+`T_WTR` for a write then a read. The first issue of a turn does not depend on any earlier turn.
- R9: A transaction issued in cycle t shows up in cycle t+`RESP_LAT` with only `resp_valid[iss_dom]` high, together with its address and type (`resp_write` is 1 for a write).
- R10: A programmed length below `MIN_TURN` is raised to `MIN_TURN`. `RD_CUT` and `WR_CUT` must both be less than `MIN_TURN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_DOM | Per-domain request strobe |
| req_write | input | NUM_DOM | Per-domain request type, 1 = write |
| req_addr | input | NUM_DOM*ADDR_W | Per-domain request address, domain d at bits d*ADDR_W |
| req_ready | output | NUM_DOM | Per-domain queue not full |
| cfg_owner | input | RING_LEN*DOM_W | Owner domain of each ring slot |
| cfg_len | input | RING_LEN*TURN_W | Turn length of each ring slot in cycles |
| cfg_offset | input | TURN_W | Cycles from reset release to the first turn |
| iss_valid | output | 1 | A transaction issues this cycle |
| iss_write | output | 1 | Type of the issued transaction, 1 = write |
| iss_dom | output | DOM_W | Domain of the issued transaction |
| iss_addr | output | ADDR_W | Address of the issued transaction |
| resp_valid | output | NUM_DOM | Per-domain completion strobe |
| resp_write | output | 1 | Type of the completed transaction |
| resp_addr | output | ADDR_W | Address of the completed transaction |

## Verification
Two kinds of event can land in the same cycle. The first is a push into a queue while that same queue's head pops. The second is a turn handover while a head is still held back by its cutoff or by a spacing gap. Dense request streams from both domains keep the queues near full during every turn, so pushes and pops coincide on the owner's queue. The ring mixes long turns, minimum-length turns and turns that are clamped up, so handovers fall both while a head is blocked and while the queue is empty. A cycle-by-cycle arithmetic model in the bench predicts every issue, ready bit and completion. Each mismatch is attributed to the rule that decided that cycle.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    typedef enum logic {
        OP_RD = 1'b0,
        OP_WR = 1'b1
    } op_e;

    // minimum spacing between two issues within one turn
    function automatic int unsigned gap_cycles(op_e prev, op_e cur,
                                               int unsigned same_gap,
                                               int unsigned rd_wr_gap,
                                               int unsigned wr_rd_gap);
        if (prev == cur)      return same_gap;
        else if (prev == OP_RD) return rd_wr_gap;
        else                  return wr_rd_gap;
    endfunction

    function automatic int unsigned max3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic int unsigned min3(int unsigned a, int unsigned b, int unsigned c);
        int unsigned m;
        m = (a < b) ? a : b;
        return (m < c) ? m : c;
    endfunction

endpackage

// File: rtl/tdm_req_fifo.sv
module tdm_req_fifo #(
    parameter int unsigned W     = 17,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tdm_turn_timer.sv
module tdm_turn_timer #(
    parameter int unsigned RING_LEN = 4,
    parameter int unsigned DOM_W    = 2,
    parameter int unsigned TURN_W   = 8,
    parameter int unsigned MIN_TURN = 23
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [RING_LEN*DOM_W-1:0]    cfg_owner,
    input  logic [RING_LEN*TURN_W-1:0]   cfg_len,
    input  logic [TURN_W-1:0]            cfg_offset,
    output logic                         active,
    output logic                         last,
    output logic [DOM_W-1:0]             owner,
    output logic [TURN_W-1:0]            tcnt,
    output logic [TURN_W-1:0]            tlen
);
    localparam int unsigned SLOT_W = (RING_LEN > 1) ? $clog2(RING_LEN) : 1;

    logic [SLOT_W-1:0] slot;
    logic [TURN_W-1:0] off_cnt;
    logic [TURN_W-1:0] raw_len;

    always_comb begin
        owner   = '0;
        raw_len = '0;
        for (int s = 0; s < RING_LEN; s++) begin
            if (slot == SLOT_W'(s)) begin
                owner   = cfg_owner[s*DOM_W +: DOM_W];
                raw_len = cfg_len[s*TURN_W +: TURN_W];
            end
        end
    end

    assign tlen   = (raw_len < TURN_W'(MIN_TURN)) ? TURN_W'(MIN_TURN) : raw_len;
    assign active = (off_cnt == cfg_offset);
    assign last   = active && (tcnt == tlen - 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            off_cnt <= '0;
            slot    <= '0;
            tcnt    <= '0;
        end else if (!active) begin
            off_cnt <= off_cnt + 1'b1;
        end else if (last) begin
            tcnt <= '0;
            slot <= (slot == SLOT_W'(RING_LEN - 1)) ? '0 : slot + 1'b1;
        end else begin
            tcnt <= tcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_resp_pipe.sv
module tdm_resp_pipe #(
    parameter int unsigned W   = 19,
    parameter int unsigned LAT = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         v [LAT];
    logic [W-1:0] d [LAT];

    for (genvar i = 0; i < LAT; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                v[i] <= 1'b0;
                d[i] <= '0;
            end else if (i == 0) begin
                v[i] <= in_valid;
                d[i] <= in_data;
            end else begin
                v[i] <= v[(i == 0) ? 0 : i - 1];
                d[i] <= d[(i == 0) ? 0 : i - 1];
            end
        end
    end

    assign out_valid = v[LAT-1];
    assign out_data  = d[LAT-1];
endmodule

// File: rtl/tdm_mem_sched.sv
module tdm_mem_sched
    import tdm_pkg::*;
#(
    parameter int unsigned NUM_DOM  = 4,
    parameter int unsigned QDEPTH   = 4,
    parameter int unsigned RING_LEN = 4,
    parameter int unsigned TURN_W   = 8,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned MIN_TURN = 23,
    parameter int unsigned RD_CUT   = 12,
    parameter int unsigned WR_CUT   = 18,
    parameter int unsigned T_FAW    = 24,
    parameter int unsigned T_RRD    = 5,
    parameter int unsigned T_CL     = 11,
    parameter int unsigned T_BURST  = 4,
    parameter int unsigned T_RTRS   = 2,
    parameter int unsigned T_WL     = 8,
    parameter int unsigned T_WTR    = 6,
    parameter int unsigned RESP_LAT = 16,
    localparam int unsigned DOM_W   = (NUM_DOM > 1) ? $clog2(NUM_DOM) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_DOM-1:0]            req_valid,
    input  logic [NUM_DOM-1:0]            req_write,
    input  logic [NUM_DOM*ADDR_W-1:0]     req_addr,
    output logic [NUM_DOM-1:0]            req_ready,
    input  logic [RING_LEN*DOM_W-1:0]     cfg_owner,
    input  logic [RING_LEN*TURN_W-1:0]    cfg_len,
    input  logic [TURN_W-1:0]             cfg_offset,
    output logic                          iss_valid,
    output logic                          iss_write,
    output logic [DOM_W-1:0]              iss_dom,
    output logic [ADDR_W-1:0]             iss_addr,
    output logic [NUM_DOM-1:0]            resp_valid,
    output logic                          resp_write,
    output logic [ADDR_W-1:0]             resp_addr
);
    localparam int GAP_SS_I = int'(T_FAW) - 3 * int'(T_RRD);
    localparam int GAP_RW_I = int'(T_CL) + int'(T_BURST) + int'(T_RTRS) - int'(T_WL);
    localparam int GAP_WR_I = int'(T_WL) + int'(T_BURST) + int'(T_WTR);
    localparam int unsigned GAP_SS  = (GAP_SS_I > 0) ? GAP_SS_I : 1;
    localparam int unsigned GAP_RW  = (GAP_RW_I > 0) ? GAP_RW_I : 1;
    localparam int unsigned GAP_WR  = (GAP_WR_I > 0) ? GAP_WR_I : 1;
    localparam int unsigned MAX_GAP = max3(GAP_SS, GAP_RW, GAP_WR);
    localparam int unsigned MIN_GAP = min3(GAP_SS, GAP_RW, GAP_WR);
    localparam int unsigned SINCE_W = $clog2(MAX_GAP + 1);
    localparam int unsigned ENT_W   = ADDR_W + 1;
    localparam int unsigned RSP_W   = DOM_W + 1 + ADDR_W;

    if (RD_CUT >= MIN_TURN || WR_CUT >= MIN_TURN) begin : g_bad_cut
        $error("dead window must be shorter than the minimum turn");
    end
    if (MIN_TURN >= (1 << TURN_W)) begin : g_bad_turn
        $error("minimum turn does not fit the turn counter");
    end

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } entry_t;

    typedef struct packed {
        logic [DOM_W-1:0]  dom;
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } resp_t;

    // ---------------- turn timing ----------------
    logic              turn_active, turn_last;
    logic [DOM_W-1:0]  owner;
    logic [TURN_W-1:0] tcnt, tlen;

    tdm_turn_timer #(
        .RING_LEN (RING_LEN),
        .DOM_W    (DOM_W),
        .TURN_W   (TURN_W),
        .MIN_TURN (MIN_TURN)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .cfg_owner  (cfg_owner),
        .cfg_len    (cfg_len),
        .cfg_offset (cfg_offset),
        .active     (turn_active),
        .last       (turn_last),
        .owner      (owner),
        .tcnt       (tcnt),
        .tlen       (tlen)
    );

    // ---------------- per-domain queues ----------------
    logic [NUM_DOM-1:0] q_empty, q_full, pop;
    entry_t             q_head [NUM_DOM];
    logic               iss;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_q
        entry_t in_ent;
        logic [ENT_W-1:0] head_raw;
        assign in_ent.op   = op_e'(req_write[d]);
        assign in_ent.addr = req_addr[d*ADDR_W +: ADDR_W];
        assign q_head[d]   = entry_t'(head_raw);
        assign pop[d]      = iss && (owner == DOM_W'(d));

        tdm_req_fifo #(
            .W     (ENT_W),
            .DEPTH (QDEPTH)
        ) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (req_valid[d]),
            .din   (in_ent),
            .pop   (pop[d]),
            .dout  (head_raw),
            .empty (q_empty[d]),
            .full  (q_full[d])
        );
    end

    assign req_ready = ~q_full;

    // ---------------- owner head selection ----------------
    entry_t sel;
    logic   sel_empty;

    always_comb begin
        sel       = '0;
        sel_empty = 1'b1;
        for (int d = 0; d < NUM_DOM; d++) begin
            if (owner == DOM_W'(d)) begin
                sel       = q_head[d];
                sel_empty = q_empty[d];
            end
        end
    end

    // ---------------- dead window per type ----------------
    logic [TURN_W:0] rd_reach, wr_reach;
    logic            rd_open, wr_open, cut_ok;

    assign rd_reach = {1'b0, tcnt} + (TURN_W+1)'(RD_CUT);
    assign wr_reach = {1'b0, tcnt} + (TURN_W+1)'(WR_CUT);
    assign rd_open  = rd_reach < {1'b0, tlen};
    assign wr_open  = wr_reach < {1'b0, tlen};
    assign cut_ok   = (sel.op == OP_WR) ? wr_open : rd_open;

    // ---------------- spacing within a turn ----------------
    logic               issued_in_turn;
    logic [SINCE_W-1:0] since;
    op_e                last_op;
    int unsigned        need;
    logic               gap_ok;

    always_comb need = gap_cycles(last_op, sel.op, GAP_SS, GAP_RW, GAP_WR);
    assign gap_ok = !issued_in_turn || (32'(since) >= need);

    assign iss = turn_active && !sel_empty && cut_ok && gap_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            issued_in_turn <= 1'b0;
            since          <= '0;
            last_op        <= OP_RD;
        end else begin
            if (iss) begin
                issued_in_turn <= 1'b1;
                since          <= SINCE_W'(1);
                last_op        <= sel.op;
            end else if (32'(since) < MAX_GAP) begin
                since <= since + 1'b1;
            end
            if (turn_last) issued_in_turn <= 1'b0;
        end
    end

    assign iss_valid = iss;
    assign iss_write = (sel.op == OP_WR);
    assign iss_dom   = owner;
    assign iss_addr  = sel.addr;

    // ---------------- completion return ----------------
    resp_t            rsp_in, rsp_out;
    logic [RSP_W-1:0] rsp_out_raw;
    logic             rsp_v;

    assign rsp_in.dom  = owner;
    assign rsp_in.op   = sel.op;
    assign rsp_in.addr = sel.addr;

    tdm_resp_pipe #(
        .W   (RSP_W),
        .LAT (RESP_LAT)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (iss),
        .in_data   (rsp_in),
        .out_valid (rsp_v),
        .out_data  (rsp_out_raw)
    );

    assign rsp_out = resp_t'(rsp_out_raw);

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_rsp
        assign resp_valid[d] = rsp_v && (rsp_out.dom == DOM_W'(d));
    end
    assign resp_write = (rsp_out.op == OP_WR);
    assign resp_addr  = rsp_out.addr;
endmodule

// File: rtl/tdm_sched_chk.sv
module tdm_sched_chk #(
    parameter int unsigned NUM_DOM  = 4,
    parameter int unsigned TURN_W   = 8,
    parameter int unsigned MIN_TURN = 23,
    parameter int unsigned RD_CUT   = 12,
    parameter int unsigned WR_CUT   = 18,
    parameter int unsigned MIN_GAP  = 2
) (
    input logic               clk,
    input logic               rst,
    input logic               iss_valid,
    input logic               iss_write,
    input logic               turn_active,
    input logic [TURN_W-1:0]  tcnt,
    input logic [TURN_W-1:0]  tlen,
    input logic [NUM_DOM-1:0] req_ready,
    input logic [NUM_DOM-1:0] pop
);
    assert_idle_before_offset_R1: assert property (@(posedge clk) disable iff (rst)
        !turn_active |-> !iss_valid);

    assert_turn_wrap_R3: assert property (@(posedge clk) disable iff (rst)
        (turn_active && tcnt == tlen - 1'b1) |=> (tcnt == '0));

    assert_read_cutoff_R5: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && !iss_write) |-> (({1'b0, tcnt} + (TURN_W+1)'(RD_CUT)) < {1'b0, tlen}));

    assert_write_cutoff_R6: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_write) |-> (({1'b0, tcnt} + (TURN_W+1)'(WR_CUT)) < {1'b0, tlen}));

    assert_len_floor_R10: assert property (@(posedge clk) disable iff (rst)
        turn_active |-> (tlen >= TURN_W'(MIN_TURN)));

    if (MIN_GAP > 1) begin : g_gap
        assert_no_back_to_back_R8: assert property (@(posedge clk) disable iff (rst)
            iss_valid |=> (!iss_valid || tcnt == '0));
    end

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_full
        assert_full_holds_R2: assert property (@(posedge clk) disable iff (rst)
            (!req_ready[d] && !pop[d]) |=> !req_ready[d]);
    end
endmodule

bind tdm_mem_sched tdm_sched_chk #(
    .NUM_DOM  (NUM_DOM),
    .TURN_W   (TURN_W),
    .MIN_TURN (MIN_TURN),
    .RD_CUT   (RD_CUT),
    .WR_CUT   (WR_CUT),
    .MIN_GAP  (MIN_GAP)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .iss_valid   (iss_valid),
    .iss_write   (iss_write),
    .turn_active (turn_active),
    .tcnt        (tcnt),
    .tlen        (tlen),
    .req_ready   (req_ready),
    .pop         (pop)
);

// File: tb/tdm_mem_sched_test.sv
module tdm_mem_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int ND   = 2;
    localparam int QD   = 4;
    localparam int RL   = 3;
    localparam int TW   = 8;
    localparam int AW   = 16;
    localparam int MINT = 23;
    localparam int RC   = 12;
    localparam int WC   = 18;
    localparam int LAT  = 6;
    // timing from T_FAW=24,T_RRD=5,T_CL=11,T_BURST=4,T_RTRS=2,T_WL=8,T_WTR=6
    localparam int G_SS = 24 - 3*5;
    localparam int G_RW = 11 + 4 + 2 - 8;
    localparam int G_WR = 8 + 4 + 6;
    localparam int G_MAX = 18;
    localparam int NSCEN = 6;
    localparam int NCYC  = 500;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [ND-1:0]    req_valid = '0;
    logic [ND-1:0]    req_write = '0;
    logic [ND*AW-1:0] req_addr  = '0;
    logic [ND-1:0]    req_ready;
    logic [RL-1:0]    cfg_owner = '0;
    logic [RL*TW-1:0] cfg_len   = '0;
    logic [TW-1:0]    cfg_offset = '0;
    logic             iss_valid, iss_write;
    logic [0:0]       iss_dom;
    logic [AW-1:0]    iss_addr;
    logic [ND-1:0]    resp_valid;
    logic             resp_write;
    logic [AW-1:0]    resp_addr;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tdm_mem_sched #(
        .NUM_DOM(ND), .QDEPTH(QD), .RING_LEN(RL), .TURN_W(TW), .ADDR_W(AW),
        .MIN_TURN(MINT), .RD_CUT(RC), .WR_CUT(WC),
        .T_FAW(24), .T_RRD(5), .T_CL(11), .T_BURST(4), .T_RTRS(2),
        .T_WL(8), .T_WTR(6), .RESP_LAT(LAT)
    ) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_ready(req_ready),
        .cfg_owner(cfg_owner), .cfg_len(cfg_len), .cfg_offset(cfg_offset),
        .iss_valid(iss_valid), .iss_write(iss_write), .iss_dom(iss_dom),
        .iss_addr(iss_addr),
        .resp_valid(resp_valid), .resp_write(resp_write), .resp_addr(resp_addr)
    );

    // model state; entry = write*65536 + addr
    int own [RL];
    int len [RL];
    int offs;
    int mq [ND][QD];
    int mcnt [ND];
    int m_off, m_slot, m_tcnt, m_since, m_last;
    bit m_issued;
    int pv [LAT];
    int pe [LAT];
    int pd [LAT];

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int d = 0; d < ND; d++) mcnt[d] = 0;
        m_off = 0; m_slot = 0; m_tcnt = 0; m_since = 0; m_last = 0; m_issued = 0;
        for (int i = 0; i < LAT; i++) begin pv[i] = 0; pe[i] = 0; pd[i] = 0; end
    endtask

    task automatic run_scen(input int s);
        int lens_tab [3][RL];
        lens_tab[0] = '{30, 23, 40};
        lens_tab[1] = '{10, 50, 23};
        lens_tab[2] = '{23, 23, 60};
        for (int i = 0; i < RL; i++) begin
            own[i] = (i + s) % 2;
            len[i] = lens_tab[s % 3][i];
            cfg_owner[i] = own[i][0];
            cfg_len[i*TW +: TW] = len[i][TW-1:0];
        end
        offs = (s * 3) % 7;
        cfg_offset = offs[TW-1:0];
        rst = 1'b1;
        req_valid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        // R1: reset state
        check(req_ready == 2'b11, "R1", "req_ready after reset", int'(req_ready), 3);
        check(!iss_valid, "R1", "iss_valid after reset", int'(iss_valid), 0);
        check(resp_valid == 2'b00, "R1", "resp_valid after reset", int'(resp_valid), 0);

        for (int cyc = 0; cyc < NCYC; cyc++) begin
            bit act, hop, cut_ok, gap_ok, e_iss;
            int tl, ow, hent, need;
            string tag;
            // drive this cycle's requests
            for (int d = 0; d < ND; d++) begin
                bit v, w;
                int a;
                v = (s == 5) ? 1'b1 : (((cyc * (d + 3) + s * 5) % (4 + s)) < 2);
                if (s == 3) w = 1'b1;
                else if (s == 4) w = 1'b0;
                else w = (((cyc / 3) + d + s) % 3) == 0;
                a = (cyc * 7 + d * 4096 + s) & 16'hFFFF;
                req_valid[d] = v;
                req_write[d] = w;
                req_addr[d*AW +: AW] = a[AW-1:0];
            end
            // predict
            act = (m_off == offs);
            tl  = (len[m_slot] < MINT) ? MINT : len[m_slot];
            ow  = own[m_slot];
            hent = (mcnt[ow] > 0) ? mq[ow][0] : 0;
            hop  = (hent >= 65536);
            cut_ok = hop ? (m_tcnt + WC < tl) : (m_tcnt + RC < tl);
            if (m_last == int'(hop)) need = G_SS;
            else if (m_last == 0) need = G_RW;
            else need = G_WR;
            gap_ok = !m_issued || (m_since >= need);
            e_iss = act && (mcnt[ow] > 0) && cut_ok && gap_ok;

            if (!act) tag = "R1";
            else if (mcnt[ow] > 0 && !cut_ok && mcnt[ow] > 1 && ((mq[ow][1] >= 65536) != hop)) tag = "R7";
            else if (mcnt[ow] > 0 && !cut_ok) tag = hop ? "R6" : "R5";
            else if (mcnt[ow] > 0 && !gap_ok) tag = "R8";
            else if (len[m_slot] < MINT && m_tcnt >= len[m_slot]) tag = "R10";
            else if (m_tcnt == 0) tag = "R3";
            else tag = "R4";

            check(iss_valid == e_iss, tag, "iss_valid", int'(iss_valid), int'(e_iss));
            if (iss_valid && e_iss) begin
                check(int'(iss_dom) == ow, "R4", "iss_dom", int'(iss_dom), ow);
                check(iss_write == hop, "R4", "iss_write", int'(iss_write), int'(hop));
                check(int'(iss_addr) == (hent & 16'hFFFF), "R2", "iss_addr order",
                      int'(iss_addr), hent & 16'hFFFF);
            end
            for (int d = 0; d < ND; d++)
                check(req_ready[d] == (mcnt[d] < QD), "R2", "req_ready",
                      int'(req_ready[d]), int'(mcnt[d] < QD));
            check(int'(resp_valid) == (pv[LAT-1] ? (1 << pd[LAT-1]) : 0), "R9", "resp_valid",
                  int'(resp_valid), pv[LAT-1] ? (1 << pd[LAT-1]) : 0);
            if (pv[LAT-1]) begin
                check(int'(resp_addr) == (pe[LAT-1] & 16'hFFFF), "R9", "resp_addr",
                      int'(resp_addr), pe[LAT-1] & 16'hFFFF);
                check(resp_write == (pe[LAT-1] >= 65536), "R9", "resp_write",
                      int'(resp_write), int'(pe[LAT-1] >= 65536));
            end

            // advance model to next cycle
            for (int i = LAT - 1; i > 0; i--) begin
                pv[i] = pv[i-1]; pe[i] = pe[i-1]; pd[i] = pd[i-1];
            end
            pv[0] = e_iss; pe[0] = hent; pd[0] = ow;
            for (int d = 0; d < ND; d++) begin
                bit was_full;
                was_full = (mcnt[d] == QD);
                if (e_iss && d == ow) begin
                    for (int i = 0; i < QD - 1; i++) mq[d][i] = mq[d][i+1];
                    mcnt[d]--;
                end
                if (req_valid[d] && !was_full) begin
                    mq[d][mcnt[d]] = (req_write[d] ? 65536 : 0) + int'(req_addr[d*AW +: AW]);
                    mcnt[d]++;
                end
            end
            if (e_iss) begin
                m_issued = 1; m_since = 1; m_last = int'(hop);
            end else if (m_since < G_MAX) begin
                m_since++;
            end
            if (!act) m_off++;
            else if (m_tcnt == tl - 1) begin
                m_tcnt = 0; m_slot = (m_slot + 1) % RL; m_issued = 0;
            end else m_tcnt++;

            @(negedge clk);
        end
    endtask

    initial begin
        for (int s = 0; s < NSCEN; s++) run_scen(s);
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule